// File: doc/BRIEF.md
# Prioritized Trace Stream Funnel

The funnel merges several trace source streams into one output stream that a trace port or an on-chip trace buffer consumes. Each source presents an 8-bit payload together with a 7-bit source identifier through a valid/ready handshake. Every cycle the funnel grants one source and forwards that beat into a single output register, along with the source identifier. A higher-priority source always wins the grant. Sources of equal priority take turns.

Once granted, a source keeps the grant for a minimum burst so that identifier switches stay rare. Each output beat carries a flag that marks a change of source identifier. Each output beat also carries a running sequence number, so a capture tool can restore the global order of the interleaved streams.

A per-source enable mask filters sources out. A disabled source is always ready, and its beats are dropped without reaching the output. Back-pressure works as follows:
- When the output register is full and the sink is not ready, every enabled source sees ready low.
- When the sink resumes, sources drain in priority order, so lower-priority sources stay stalled longest.

Top module: `trace_funnel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0.
- R2: A source whose `src_enable` bit is 0 sees `in_ready` high at all times, and none of its beats ever appears on the output.
- R3: When several enabled sources request at the same time and no burst is locked, the source with the numerically largest 2-bit priority field (`src_prio[2i+1:2i]`) is granted first.
- R4: Among requesting sources of the same top priority, the grant rotates round-robin, starting from the index after the last granted source.
- R5: A granted source keeps the grant for 4 consecutive output beats while it keeps its valid high, even if a higher-priority source starts requesting meanwhile.
- R6: If the granted source drops valid before completing its burst, the lock is released and another requesting source is forwarded with no idle output cycle.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output fields stay stable and no enabled source sees `in_ready` high.
- R8: `out_mark` is 1 on the first beat after reset, and on every beat whose `out_id` differs from the previous beat's `out_id`; otherwise it is 0.
- R9: `out_seq` is 0 on the first output beat after reset and increases by one, modulo 2^8, on each subsequent beat.
- R10: The payload and source identifier of each beat pass through unchanged, and each source's beats leave in the order they were accepted.
- R11: At most one enabled source completes a handshake in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_enable | input | 4 | Per-source filter; 0 drops that source |
| src_prio | input | 8 | Two priority bits per source, source i at [2i+1:2i] |
| in_valid | input | 4 | Source beat valid |
| in_ready | output | 4 | Source beat accepted |
| in_data | input | 32 | Payloads, source i at [8i+7:8i] |
| in_id | input | 28 | Source identifiers, source i at [7i+6:7i] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink can take the beat |
| out_data | output | 8 | Forwarded payload |
| out_id | output | 7 | Forwarded source identifier |
| out_mark | output | 1 | Identifier change marker |
| out_seq | output | 8 | Output beat sequence number |

## Verification
The bench tests a higher-priority source that arrives in the middle of a locked burst. A design that preempts there would interleave the two bursts, and one that ignores the burst count would let the lower source run to the end.

Two equal-priority streams must alternate in runs of four beats. A broken rotation pointer shows up as one source being starved.

A burst that ends early must hand over with no bubble. A stalled sink must freeze the output and stop every enabled source; a design that leaks ready there loses or duplicates beats, which the per-source beat numbering exposes.

A disabled source must be swallowed without stalling. The marker and sequence number are checked on every beat, so a dropped or repeated beat shows up as a sequence gap.

// File: rtl/trace_funnel_pkg.sv
package trace_funnel_pkg;
  localparam int DATA_W = 8;
  localparam int ID_W   = 7;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DATA_W-1:0] data;
  } beat_t;
endpackage

// File: rtl/tf_arbiter.sv
module tf_arbiter #(
  parameter int N_SRC   = 4,
  parameter int PRIO_W  = 2,
  parameter int BURST   = 4,
  localparam int IW     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int CW     = $clog2(BURST + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        req,
  input  logic [N_SRC*PRIO_W-1:0] prio,
  input  logic                    advance,
  output logic                    gnt_valid,
  output logic [IW-1:0]           gnt_idx
);
  logic [IW-1:0]     owner_q;
  logic [IW-1:0]     rr_q;
  logic              locked_q;
  logic [CW-1:0]     cnt_q;
  logic [PRIO_W-1:0] top_prio;
  logic [IW-1:0]     pick;
  logic              found;
  logic              hold;

  // Highest priority among the current requesters.
  always_comb begin
    top_prio = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && (prio[i*PRIO_W +: PRIO_W] > top_prio))
        top_prio = prio[i*PRIO_W +: PRIO_W];
    end
  end

  // Rotating search among the sources at the top priority.
  always_comb begin
    found = 1'b0;
    pick  = rr_q;
    for (int k = 1; k <= N_SRC; k++) begin
      logic [IW-1:0] idx;
      idx = IW'((int'(rr_q) + k) % N_SRC);
      if (!found && req[idx] && (prio[int'(idx)*PRIO_W +: PRIO_W] == top_prio)) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  assign hold      = locked_q && req[owner_q] && (cnt_q < CW'(BURST));
  assign gnt_valid = |req;
  assign gnt_idx   = hold ? owner_q : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q  <= '0;
      rr_q     <= IW'(N_SRC - 1);
      locked_q <= 1'b0;
      cnt_q    <= '0;
    end else if (advance) begin
      if (hold) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        owner_q  <= gnt_idx;
        rr_q     <= gnt_idx;
        locked_q <= 1'b1;
        cnt_q    <= CW'(1);
      end
    end else if (locked_q && !req[owner_q]) begin
      locked_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tf_filter.sv
module tf_filter #(
  parameter int N_SRC = 4,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] src_enable,
  input  logic [N_SRC-1:0] in_valid,
  input  logic             gnt_valid,
  input  logic [IW-1:0]    gnt_idx,
  input  logic             load_ok,
  output logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] in_ready
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign req[i]      = in_valid[i] & src_enable[i];
    assign in_ready[i] = src_enable[i] ?
                         (gnt_valid && load_ok && (gnt_idx == IW'(i))) : 1'b1;
  end
endmodule

// File: rtl/tf_outreg.sv
module tf_outreg
  import trace_funnel_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  beat_t                beat_in,
  output logic                 load_ok,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_data,
  output logic [ID_W-1:0]      out_id,
  output logic                 out_mark,
  output logic [SEQ_W-1:0]     out_seq
);
  logic [ID_W-1:0]  last_id_q;
  logic             seen_q;
  logic [SEQ_W-1:0] next_seq_q;

  assign load_ok = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_id     <= '0;
      out_mark   <= 1'b0;
      out_seq    <= '0;
      last_id_q  <= '0;
      seen_q     <= 1'b0;
      next_seq_q <= '0;
    end else if (load_ok) begin
      out_valid <= load;
      if (load) begin
        out_data   <= beat_in.data;
        out_id     <= beat_in.id;
        out_mark   <= !seen_q || (beat_in.id != last_id_q);
        out_seq    <= next_seq_q;
        last_id_q  <= beat_in.id;
        seen_q     <= 1'b1;
        next_seq_q <= next_seq_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trace_funnel.sv
module trace_funnel
  import trace_funnel_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int PRIO_W = 2,
  parameter int BURST  = 4,
  parameter int SEQ_W  = 8,
  localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        src_enable,
  input  logic [N_SRC*PRIO_W-1:0] src_prio,
  input  logic [N_SRC-1:0]        in_valid,
  output logic [N_SRC-1:0]        in_ready,
  input  logic [N_SRC*DATA_W-1:0] in_data,
  input  logic [N_SRC*ID_W-1:0]   in_id,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic [ID_W-1:0]         out_id,
  output logic                    out_mark,
  output logic [SEQ_W-1:0]        out_seq
);
  logic [N_SRC-1:0] req;
  logic             gnt_valid;
  logic [IW-1:0]    gnt_idx;
  logic             load_ok;
  logic             load;
  beat_t            beats [N_SRC];
  beat_t            sel_beat;

  for (genvar i = 0; i < N_SRC; i++) begin : g_beat
    assign beats[i].data = in_data[i*DATA_W +: DATA_W];
    assign beats[i].id   = in_id[i*ID_W +: ID_W];
  end

  assign sel_beat = beats[gnt_idx];
  assign load     = gnt_valid && load_ok;

  tf_filter #(.N_SRC(N_SRC)) u_filter (
    .src_enable (src_enable),
    .in_valid   (in_valid),
    .gnt_valid  (gnt_valid),
    .gnt_idx    (gnt_idx),
    .load_ok    (load_ok),
    .req        (req),
    .in_ready   (in_ready)
  );

  tf_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .BURST(BURST)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .prio      (src_prio),
    .advance   (load),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  tf_outreg #(.SEQ_W(SEQ_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .beat_in   (sel_beat),
    .load_ok   (load_ok),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_id    (out_id),
    .out_mark  (out_mark),
    .out_seq   (out_seq)
  );
endmodule

// File: rtl/trace_funnel_chk.sv
module trace_funnel_chk #(
  parameter int N_SRC = 4,
  parameter int SEQ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_enable,
  input logic [N_SRC-1:0] in_valid,
  input logic [N_SRC-1:0] in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic [6:0]       out_id,
  input logic             out_mark,
  input logic [SEQ_W-1:0] out_seq
);
  logic live_q;
  always_ff @(posedge clk) live_q <= rst_n;

  assert_disabled_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~src_enable & ~in_ready) == '0));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_id)
                                   && $stable(out_seq) && $stable(out_mark)));

  assert_stall_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> ((in_ready & src_enable) == '0));

  assert_one_handshake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_valid & in_ready & src_enable));

  assert_seq_step_R9: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (out_valid && out_ready) |=> (!out_valid || (out_seq == $past(out_seq) + 1'b1)));

  assert_mark_R8: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (out_valid && out_ready) |=> (!out_valid || (out_mark == (out_id != $past(out_id)))));
endmodule

bind trace_funnel trace_funnel_chk #(.N_SRC(N_SRC), .SEQ_W(SEQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_enable (src_enable),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_id     (out_id),
  .out_mark   (out_mark),
  .out_seq    (out_seq)
);

// File: tb/trace_funnel_tb.sv
module trace_funnel_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   src_enable;
  logic [7:0]   src_prio;
  logic [3:0]   in_valid;
  logic [3:0]   in_ready;
  logic [31:0]  in_data;
  logic [27:0]  in_id;
  logic         out_valid;
  logic         out_ready;
  logic [7:0]   out_data;
  logic [6:0]   out_id;
  logic         out_mark;
  logic [7:0]   out_seq;

  always #5 clk = ~clk;

  trace_funnel u_dut (
    .clk(clk), .rst_n(rst_n), .src_enable(src_enable), .src_prio(src_prio),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_id(in_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_id(out_id), .out_mark(out_mark), .out_seq(out_seq)
  );

  int checks = 0;
  int fails  = 0;
  int rem [N];
  int cnt [N];
  int exp_beat [N];
  int hs_total = 0;
  int total_out = 0;
  int cyc = 0;
  logic [6:0] last_id = '0;
  bit   seen = 0;
  int   nlog = 0;
  int   log_src [64];
  int   log_cyc [64];
  bit   drop_watch = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [6:0] sid(int i);
    return 7'h40 | 7'(i);
  endfunction

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      in_valid[i]          = rem[i] > 0;
      in_data[i*8 +: 8]    = {2'(i), 6'(cnt[i])};
      in_id[i*7 +: 7]      = sid(i);
    end
  endtask

  task automatic tick();
    bit hs [N];
    #1;
    for (int i = 0; i < N; i++) begin
      hs[i] = in_valid[i] && in_ready[i];
      if (hs[i] && src_enable[i]) hs_total++;
      if (drop_watch && !src_enable[i] && in_valid[i])
        check(in_ready[i] == 1'b1, "R2 ready", int'(in_ready[i]), 1);
    end
    if (out_valid && out_ready) begin
      int s;
      s = int'(out_id) - 'h40;
      check(out_mark == (!seen || out_id != last_id), "R8", int'(out_mark),
            int'(!seen || out_id != last_id));
      check(out_seq == 8'(total_out), "R9", int'(out_seq), total_out % 256);
      if (s >= 0 && s < N) begin
        check(out_data == {2'(s), 6'(exp_beat[s])}, "R10", int'(out_data),
              int'({2'(s), 6'(exp_beat[s])}));
        check(src_enable[s] == 1'b1, "R2 output", s, -1);
        exp_beat[s]++;
      end else begin
        check(0, "R10 id", int'(out_id), 'h40);
      end
      if (nlog < 64) begin
        log_src[nlog] = s;
        log_cyc[nlog] = cyc;
        nlog++;
      end
      total_out++;
      last_id = out_id;
      seen = 1;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    for (int i = 0; i < N; i++) if (hs[i]) begin rem[i]--; cnt[i]++; end
    drive();
  endtask

  task automatic run_idle();
    for (int k = 0; k < 200; k++) begin
      if (rem[0] == 0 && rem[1] == 0 && rem[2] == 0 && rem[3] == 0 && !out_valid) break;
      tick();
    end
  endtask

  task automatic start(int r0, int r1, int r2, int r3);
    rem[0] = r0; rem[1] = r1; rem[2] = r2; rem[3] = r3;
    nlog = 0;
    drive();
  endtask

  task automatic expect_order(string req, int n, int exp []);
    check(nlog == n, {req, " count"}, nlog, n);
    for (int k = 0; k < n && k < nlog; k++)
      check(log_src[k] == exp[k], req, log_src[k], exp[k]);
  endtask

  task automatic t_reset();
    rst_n = 0; out_ready = 1; src_enable = 4'hF; src_prio = '0;
    for (int i = 0; i < N; i++) begin rem[i] = 0; cnt[i] = 0; exp_beat[i] = 0; end
    drive();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 after reset", int'(out_valid), 0);
  endtask

  task automatic t_single();
    start(0, 3, 0, 0);
    run_idle();
    expect_order("R10 single", 3, '{1, 1, 1});
  endtask

  task automatic t_priority();
    src_prio = 8'b11_11_00_01;
    start(4, 0, 4, 0);
    run_idle();
    expect_order("R3", 8, '{2, 2, 2, 2, 0, 0, 0, 0});
  endtask

  task automatic t_round_robin();
    int first;
    src_prio = 8'b00_00_10_10;
    start(8, 8, 0, 0);
    run_idle();
    check(nlog == 16, "R4 count", nlog, 16);
    first = log_src[0];
    for (int k = 0; k < 16 && k < nlog; k++) begin
      int e;
      e = ((k / 4) % 2 == 0) ? first : 1 - first;
      check(log_src[k] == e, "R4", log_src[k], e);
    end
  endtask

  task automatic t_lock();
    src_prio = 8'b11_00_00_00;
    start(0, 6, 0, 0);
    tick();
    tick();
    rem[3] = 2;
    drive();
    run_idle();
    expect_order("R5", 8, '{1, 1, 1, 1, 3, 3, 1, 1});
  endtask

  task automatic t_release();
    src_prio = 8'b00_01_01_00;
    start(0, 2, 2, 0);
    run_idle();
    check(nlog == 4, "R6 count", nlog, 4);
    if (nlog == 4) begin
      check(log_src[0] == log_src[1] && log_src[2] == log_src[3] && log_src[1] != log_src[2],
            "R6 grouping", log_src[2], 1 - log_src[1]);
      check(log_cyc[2] == log_cyc[1] + 1, "R6 no bubble", log_cyc[2], log_cyc[1] + 1);
    end
  endtask

  task automatic t_filter();
    src_enable = 4'b1110;
    src_prio = 8'b00_00_00_11;
    drop_watch = 1;
    start(3, 2, 0, 0);
    run_idle();
    drop_watch = 0;
    check(rem[0] == 0, "R2 drained", rem[0], 0);
    expect_order("R2", 2, '{1, 1});
    src_enable = 4'hF;
    cnt[0] = 0;
  endtask

  task automatic t_stall();
    logic [7:0] held;
    int base;
    src_prio = 8'b11_00_00_00;
    out_ready = 0;
    start(0, 2, 0, 2);
    tick();
    check(out_valid == 1'b1, "R7 loaded", int'(out_valid), 1);
    held = out_data;
    base = hs_total;
    for (int k = 0; k < 4; k++) tick();
    check(hs_total == base, "R7 no handshake", hs_total - base, 0);
    check(out_data == held, "R7 stable", int'(out_data), int'(held));
    check(in_ready[1] == 1'b0 && in_ready[3] == 1'b0, "R7 ready low", int'(in_ready), 0);
    out_ready = 1;
    run_idle();
    expect_order("R7 drain", 4, '{3, 3, 1, 1});
  endtask

  initial begin
    src_enable = 4'hF; src_prio = '0; in_valid = '0; in_data = '0; in_id = '0;
    out_ready = 1; rst_n = 0;
    @(negedge clk);
    t_reset();
    t_single();
    t_priority();
    t_round_robin();
    t_lock();
    t_release();
    t_filter();
    t_stall();
    check(hs_total == total_out, "R11 accounting", hs_total, total_out);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule